// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Demap Commands

This block is a small fully associative translation buffer. Each entry binds a virtual page number and an address-space context to a 64-bit data word. One port performs lookups: it takes a page number and a context and, one cycle later, returns a hit flag, the index of the matching entry, its data word and a flag for more than one match.

A second port is a register-style maintenance interface with four targets, selected by `mnt_sel`:
- **Fill** replaces the entry at a hardware replacement pointer.
- **Direct** writes or reads an entry at an explicit index.
- **Tag** reads back the tag of an entry.
- **Demap** executes a demap command word.

A demap clears, in one cycle and in parallel, either the entries of one page within one context or every entry of one context. The command word selects the context from one of three sources.

A fill does not look for an older copy of the same page. Software must demap a page before it refills it. If it does not, later lookups raise the multiple-match flag.

Top module: `vtlb`

## Requirements
- R1: After reset, no entry is valid: every lookup misses, a tag read returns 0, and the replacement pointer `repl_ptr` is 0.
- R2: A write with `mnt_sel`=0 (fill) installs an entry at index `repl_ptr`. Its page number is `mnt_va[63:13]`, its context is `ctx_pri` and its data is `mnt_wdata`. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R3: `rp_we` loads `rp_wdata` into `repl_ptr` and takes precedence over the advance of R2. A fill in the same cycle still uses the old pointer.
- R4: A write with `mnt_sel`=1 (direct) installs the same tag and data fields as R2 at index `mnt_idx`. It leaves `repl_ptr` unchanged.
- R5: A read raises `rd_valid` on the next cycle. With `mnt_sel`=1, `rd_data` is the data word of entry `mnt_idx`. With `mnt_sel`=2, `rd_data` is {page number, context} of that entry (page number in bits 63:13, context in bits 12:0), or 0 if the entry is invalid.
- R6: A read with `mnt_sel`=0 or 3 is unsupported: it returns `rd_unsup`=1 and `rd_data`=0.
- R7: A lookup (`lk_req`) is answered on the next cycle with `lk_ack`=1. An entry matches when it is valid and both its page number and its context are equal to the request. On a match, `lk_hit`=1 and `lk_idx`/`lk_data` belong to the matching entry; otherwise `lk_hit`=0.
- R8: When two or more valid entries match a lookup, `lk_multi`=1, `lk_hit`=1 and `lk_idx` is the lowest matching index.
- R9: A write with `mnt_sel`=3 and bit 6 of `mnt_va` clear (demap page) invalidates every valid entry whose page number equals `mnt_va[63:13]` and whose context equals the selected context.
- R10: A demap with bit 6 of `mnt_va` set (demap context) invalidates every valid entry whose context equals the selected context, whatever its page number.
- R11: Bits 5:4 of the demap word select the context: 0 selects `ctx_pri`, 1 selects `ctx_sec`, 2 selects context 0. The value 3 makes the demap have no effect.
- R12: A lookup in the same cycle as a demap sees the contents from before the demap. The next lookup sees the contents after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mnt_we | input | 1 | Maintenance write strobe |
| mnt_re | input | 1 | Maintenance read strobe |
| mnt_sel | input | 2 | Target: 0 fill, 1 direct, 2 tag, 3 demap |
| mnt_idx | input | IDXW (4) | Entry index for direct and tag access |
| mnt_va | input | VAW (64) | Virtual address of a new tag, or the demap command word |
| mnt_wdata | input | DW (64) | Data word for fill and direct writes |
| ctx_pri | input | CTXW (13) | Primary context; tags new entries |
| ctx_sec | input | CTXW (13) | Secondary context for demap selection |
| rp_we | input | 1 | Load strobe for the replacement pointer |
| rp_wdata | input | IDXW (4) | New replacement pointer value |
| repl_ptr | output | IDXW (4) | Current replacement pointer |
| rd_valid | output | 1 | Read result valid |
| rd_unsup | output | 1 | Read target was unsupported |
| rd_data | output | DW (64) | Read result |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPNW (51) | Lookup page number |
| lk_ctx | input | CTXW (13) | Lookup context |
| lk_ack | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup matched |
| lk_multi | output | 1 | More than one entry matched |
| lk_idx | output | IDXW (4) | Index of the (lowest) matching entry |
| lk_data | output | DW (64) | Data word of the matching entry |

## Verification
A lookup and a demap can be issued in the same cycle. The bench does this by raising `lk_req` and a demap-page write at the same falling edge, both aimed at the same entry. It expects that lookup to still report a hit with the old data, and the lookup that follows to miss. A fill combined with a pointer load in one cycle is also provoked. It is judged by the entry written at the old pointer and by the loaded value then showing on `repl_ptr`.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  typedef enum logic [1:0] {
    PORT_FILL   = 2'd0,
    PORT_DIRECT = 2'd1,
    PORT_TAG    = 2'd2,
    PORT_DEMAP  = 2'd3
  } mnt_port_e;

  typedef enum logic [1:0] {
    CS_PRI  = 2'd0,
    CS_SEC  = 2'd1,
    CS_NUC  = 2'd2,
    CS_NONE = 2'd3
  } ctx_src_e;

  localparam int DM_KIND_BIT = 6;
  localparam int DM_SRC_LO   = 4;
endpackage

// File: rtl/vtlb_match.sv
module vtlb_match #(
  parameter int N    = 16,
  parameter int VPNW = 51,
  parameter int CTXW = 13
) (
  input  logic [N-1:0]           valid,
  input  logic [N-1:0][VPNW-1:0] vpn_q,
  input  logic [N-1:0][CTXW-1:0] ctx_q,
  input  logic [VPNW-1:0]        lk_vpn,
  input  logic [CTXW-1:0]        lk_ctx,
  input  logic                   dm_en,
  input  logic                   dm_ctx_only,
  input  logic [VPNW-1:0]        dm_vpn,
  input  logic [CTXW-1:0]        dm_ctx,
  output logic [N-1:0]           lk_vec,
  output logic [N-1:0]           dm_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic ctx_eq;
    assign lk_vec[i] = valid[i] && (vpn_q[i] == lk_vpn) && (ctx_q[i] == lk_ctx);
    assign ctx_eq    = (ctx_q[i] == dm_ctx);
    assign dm_vec[i] = dm_en && valid[i] && ctx_eq && (dm_ctx_only || (vpn_q[i] == dm_vpn));
  end
endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
  parameter int N    = 16,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    vec,
  output logic [IDXW-1:0] idx,
  output logic            any,
  output logic            multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDXW'(i);
    end
  end

  always_comb begin
    any   = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      multi = multi | (any & vec[i]);
      any   = any | vec[i];
    end
  end
endmodule

// File: rtl/vtlb_rptr.sv
module vtlb_rptr #(
  parameter int N    = 16,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            ld,
  input  logic [IDXW-1:0] ld_val,
  output logic [IDXW-1:0] ptr
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (ld)  ptr <= ld_val;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/vtlb.sv
module vtlb
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VAW     = 64,
  parameter int PGSH    = 13,
  parameter int CTXW    = 13,
  parameter int DW      = 64,
  localparam int IDXW   = $clog2(ENTRIES),
  localparam int VPNW   = VAW - PGSH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mnt_we,
  input  logic            mnt_re,
  input  logic [1:0]      mnt_sel,
  input  logic [IDXW-1:0] mnt_idx,
  input  logic [VAW-1:0]  mnt_va,
  input  logic [DW-1:0]   mnt_wdata,
  input  logic [CTXW-1:0] ctx_pri,
  input  logic [CTXW-1:0] ctx_sec,
  input  logic            rp_we,
  input  logic [IDXW-1:0] rp_wdata,
  output logic [IDXW-1:0] repl_ptr,
  output logic            rd_valid,
  output logic            rd_unsup,
  output logic [DW-1:0]   rd_data,
  input  logic            lk_req,
  input  logic [VPNW-1:0] lk_vpn,
  input  logic [CTXW-1:0] lk_ctx,
  output logic            lk_ack,
  output logic            lk_hit,
  output logic            lk_multi,
  output logic [IDXW-1:0] lk_idx,
  output logic [DW-1:0]   lk_data
);
  localparam int TAGW = VPNW + CTXW;

  logic [ENTRIES-1:0]           valid;
  logic [ENTRIES-1:0][VPNW-1:0] vpn_q;
  logic [ENTRIES-1:0][CTXW-1:0] ctx_q;
  logic [DW-1:0]                dmem [ENTRIES];

  logic            fill_we, dir_we, wr_en, dm_en, dm_ctx_only;
  logic [IDXW-1:0] wr_idx;
  ctx_src_e        dm_src;
  logic [CTXW-1:0] dm_ctx;
  logic [ENTRIES-1:0] lk_vec, dm_vec;
  logic [IDXW-1:0] lk_idx_c;
  logic            lk_any_c, lk_multi_c;

  assign fill_we     = mnt_we && (mnt_sel == PORT_FILL);
  assign dir_we      = mnt_we && (mnt_sel == PORT_DIRECT);
  assign wr_en       = fill_we || dir_we;
  assign wr_idx      = fill_we ? repl_ptr : mnt_idx;
  assign dm_src      = ctx_src_e'(mnt_va[DM_SRC_LO +: 2]);
  assign dm_ctx_only = mnt_va[DM_KIND_BIT];
  assign dm_en       = mnt_we && (mnt_sel == PORT_DEMAP) && (dm_src != CS_NONE);

  always_comb begin
    case (dm_src)
      CS_PRI:  dm_ctx = ctx_pri;
      CS_SEC:  dm_ctx = ctx_sec;
      default: dm_ctx = '0;
    endcase
  end

  vtlb_match #(.N(ENTRIES), .VPNW(VPNW), .CTXW(CTXW)) u_match (
    .valid(valid), .vpn_q(vpn_q), .ctx_q(ctx_q),
    .lk_vpn(lk_vpn), .lk_ctx(lk_ctx),
    .dm_en(dm_en), .dm_ctx_only(dm_ctx_only),
    .dm_vpn(mnt_va[VAW-1:PGSH]), .dm_ctx(dm_ctx),
    .lk_vec(lk_vec), .dm_vec(dm_vec)
  );

  vtlb_prio #(.N(ENTRIES), .IDXW(IDXW)) u_prio (
    .vec(lk_vec), .idx(lk_idx_c), .any(lk_any_c), .multi(lk_multi_c)
  );

  vtlb_rptr #(.N(ENTRIES), .IDXW(IDXW)) u_rptr (
    .clk(clk), .rst(rst), .adv(fill_we), .ld(rp_we), .ld_val(rp_wdata), .ptr(repl_ptr)
  );

  // Valid bits: parallel clear by demap, set by a write
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else begin
      valid <= valid & ~dm_vec;
      if (wr_en) valid[wr_idx] <= 1'b1;
    end
  end

  // Tag storage (no reset needed, qualified by valid)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= mnt_va[VAW-1:PGSH];
      ctx_q[wr_idx] <= ctx_pri;
    end
  end

  // Data storage: one write port, two registered read ports
  logic [DW-1:0] lk_data_q, rd_dmem_q;
  always_ff @(posedge clk) begin
    if (wr_en) dmem[wr_idx] <= mnt_wdata;
    lk_data_q <= dmem[lk_idx_c];
    rd_dmem_q <= dmem[mnt_idx];
  end
  assign lk_data = lk_data_q;

  // Registered lookup and read status
  logic [1:0]    rd_kind;
  logic [DW-1:0] tag_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_ack   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_multi <= 1'b0;
      lk_idx   <= '0;
      rd_valid <= 1'b0;
      rd_unsup <= 1'b0;
      rd_kind  <= PORT_FILL;
      tag_q    <= '0;
    end else begin
      lk_ack   <= lk_req;
      lk_hit   <= lk_req && lk_any_c;
      lk_multi <= lk_req && lk_multi_c;
      lk_idx   <= lk_idx_c;
      rd_valid <= mnt_re;
      rd_unsup <= mnt_re && ((mnt_sel == PORT_FILL) || (mnt_sel == PORT_DEMAP));
      rd_kind  <= mnt_sel;
      tag_q    <= valid[mnt_idx] ? DW'({vpn_q[mnt_idx], ctx_q[mnt_idx]}) : '0;
    end
  end

  always_comb begin
    if (!rd_valid)                   rd_data = '0;
    else if (rd_kind == PORT_DIRECT) rd_data = rd_dmem_q;
    else if (rd_kind == PORT_TAG)    rd_data = tag_q;
    else                             rd_data = '0;
  end

  if (TAGW > DW) begin : g_tagw_chk
    initial $error("tag wider than data word");
  end
endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk #(
  parameter int ENTRIES = 16,
  parameter int IDXW    = 4,
  parameter int DW      = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            mnt_we,
  input logic            mnt_re,
  input logic [1:0]      mnt_sel,
  input logic            rp_we,
  input logic [IDXW-1:0] rp_wdata,
  input logic [IDXW-1:0] repl_ptr,
  input logic            rd_valid,
  input logic            rd_unsup,
  input logic [DW-1:0]   rd_data,
  input logic            lk_req,
  input logic            lk_ack,
  input logic            lk_hit,
  input logic            lk_multi
);
  // R7
  lk_ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_ack);

  // R7
  lk_no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_ack && !lk_hit);

  // R8
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit);

  // R5
  rd_follows_re_chk: assert property (@(posedge clk) disable iff (rst)
    mnt_re |=> rd_valid);

  // R6
  unsup_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_unsup |-> (rd_valid && rd_data == '0));

  // R2
  ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (mnt_we && mnt_sel == 2'd0 && !rp_we) |=>
      repl_ptr == (($past(repl_ptr) == IDXW'(ENTRIES - 1)) ? '0 : $past(repl_ptr) + 1'b1));

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    rp_we |=> repl_ptr == $past(rp_wdata));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rp_we && !(mnt_we && mnt_sel == 2'd0)) |=> $stable(repl_ptr));
endmodule

bind vtlb vtlb_chk #(.ENTRIES(ENTRIES), .IDXW(IDXW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mnt_we(mnt_we), .mnt_re(mnt_re), .mnt_sel(mnt_sel),
  .rp_we(rp_we), .rp_wdata(rp_wdata), .repl_ptr(repl_ptr),
  .rd_valid(rd_valid), .rd_unsup(rd_unsup), .rd_data(rd_data),
  .lk_req(lk_req), .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_multi(lk_multi)
);

// File: tb/sim_vtlb.sv
`timescale 1ns/1ps
module sim_vtlb;
  localparam int N = 16;
  localparam int IW = 4;
  localparam int VW = 51;
  localparam int CW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          mnt_we = 0, mnt_re = 0;
  logic [1:0]    mnt_sel = 0;
  logic [IW-1:0] mnt_idx = 0;
  logic [63:0]   mnt_va = 0, mnt_wdata = 0;
  logic [CW-1:0] ctx_pri = 0, ctx_sec = 0;
  logic          rp_we = 0;
  logic [IW-1:0] rp_wdata = 0;
  logic [IW-1:0] repl_ptr;
  logic          rd_valid, rd_unsup;
  logic [63:0]   rd_data;
  logic          lk_req = 0;
  logic [VW-1:0] lk_vpn = 0;
  logic [CW-1:0] lk_ctx = 0;
  logic          lk_ack, lk_hit, lk_multi;
  logic [IW-1:0] lk_idx;
  logic [63:0]   lk_data;

  vtlb u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit            m_v   [N];
  logic [VW-1:0] m_vpn [N];
  logic [CW-1:0] m_ctx [N];
  logic [63:0]   m_dat [N];
  int            m_ptr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dm_word(input logic [VW-1:0] vpn, input bit ctx_kind, input logic [1:0] src);
    return {vpn, 6'b0, ctx_kind, src, 4'b0};
  endfunction

  function automatic logic [VW-1:0] vpn_of(input int i);
    return VW'(51'h4_0000 + i * 7);
  endfunction

  task automatic fill(input logic [VW-1:0] vpn, input logic [CW-1:0] ctx, input logic [63:0] d,
                      input bit ld, input logic [IW-1:0] ldv);
    @(negedge clk);
    mnt_we = 1; mnt_sel = 2'd0; mnt_va = {vpn, 13'h0a5}; mnt_wdata = d; ctx_pri = ctx;
    rp_we = ld; rp_wdata = ldv;
    @(negedge clk);
    mnt_we = 0; rp_we = 0;
    m_v[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_ctx[m_ptr] = ctx; m_dat[m_ptr] = d;
    m_ptr = ld ? int'(ldv) : (m_ptr + 1) % N;
  endtask

  task automatic direct_wr(input int idx, input logic [VW-1:0] vpn, input logic [CW-1:0] ctx, input logic [63:0] d);
    @(negedge clk);
    mnt_we = 1; mnt_sel = 2'd1; mnt_idx = IW'(idx); mnt_va = {vpn, 13'h0}; mnt_wdata = d; ctx_pri = ctx;
    @(negedge clk);
    mnt_we = 0;
    m_v[idx] = 1; m_vpn[idx] = vpn; m_ctx[idx] = ctx; m_dat[idx] = d;
  endtask

  task automatic model_demap(input logic [63:0] w);
    logic [CW-1:0] c;
    if (w[5:4] == 2'd3) return;
    c = (w[5:4] == 2'd0) ? ctx_pri : (w[5:4] == 2'd1) ? ctx_sec : '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_ctx[i] == c && (w[6] || m_vpn[i] == w[63:13])) m_v[i] = 0;
  endtask

  task automatic demap(input logic [63:0] w);
    @(negedge clk);
    mnt_we = 1; mnt_sel = 2'd3; mnt_va = w;
    @(negedge clk);
    mnt_we = 0;
    model_demap(w);
  endtask

  task automatic mread(input logic [1:0] sel, input int idx, output logic [63:0] d, output bit v, output bit u);
    @(negedge clk);
    mnt_re = 1; mnt_sel = sel; mnt_idx = IW'(idx);
    @(negedge clk);
    mnt_re = 0;
    d = rd_data; v = rd_valid; u = rd_unsup;
  endtask

  task automatic lk_expect(input logic [VW-1:0] vpn, input logic [CW-1:0] ctx, input string req);
    int cnt = 0, first = 0;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == vpn && m_ctx[i] == ctx) begin cnt++; first = i; end
    chk(lk_ack == 1, req, 64'(lk_ack), 64'd1);
    chk(lk_hit == (cnt > 0), req, 64'(lk_hit), 64'(cnt > 0));
    chk(lk_multi == (cnt > 1), req, 64'(lk_multi), 64'(cnt > 1));
    if (cnt > 0) chk(lk_idx == IW'(first), req, 64'(lk_idx), 64'(first));
    if (cnt == 1) chk(lk_data == m_dat[first], req, lk_data, m_dat[first]);
  endtask

  task automatic lookup(input logic [VW-1:0] vpn, input logic [CW-1:0] ctx, input string req);
    @(negedge clk);
    lk_req = 1; lk_vpn = vpn; lk_ctx = ctx;
    @(negedge clk);
    lk_req = 0;
    lk_expect(vpn, ctx, req);
  endtask

  task automatic sweep(input string req);
    logic [63:0] d; bit v, u;
    for (int i = 0; i < N; i++) begin
      lookup(m_vpn[i], m_ctx[i], req);
      mread(2'd2, i, d, v, u);
      chk(d == (m_v[i] ? {m_vpn[i], m_ctx[i]} : 64'd0), {req, " tag"}, d,
          m_v[i] ? {m_vpn[i], m_ctx[i]} : 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d; bit v, u;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = vpn_of(i); m_ctx[i] = CW'(i % 4 + 1); m_dat[i] = 0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    @(negedge clk);
    chk(repl_ptr == 0, "R1 ptr", 64'(repl_ptr), 0);
    lookup(vpn_of(3), 13'd4, "R1 lookup");
    mread(2'd2, 5, d, v, u);
    chk(d == 0, "R1 tag", d, 0);

    // R2: fill all entries through the pointer, wrap checked at the end
    for (int i = 0; i < N; i++) begin
      fill(vpn_of(i), CW'(i % 4 + 1), 64'hD000_0000_0000_0000 | 64'(i * 32'h1111), 0, '0);
      chk(repl_ptr == IW'((i + 1) % N), "R2 ptr", 64'(repl_ptr), 64'((i + 1) % N));
    end
    sweep("R2/R7 sweep");

    // R7: wrong context and unknown page miss
    lookup(vpn_of(2), 13'd9, "R7 wrong ctx");
    lookup(51'h7_7777, 13'd1, "R7 unknown page");

    // R5: data reads
    for (int i = 0; i < N; i += 5) begin
      mread(2'd1, i, d, v, u);
      chk(v && !u && d == m_dat[i], "R5 data read", d, m_dat[i]);
    end

    // R6: unsupported reads
    mread(2'd0, 1, d, v, u);
    chk(v && u && d == 0, "R6 fill read", {62'd0, u, v}, 64'd3);
    mread(2'd3, 1, d, v, u);
    chk(v && u && d == 0, "R6 demap read", {62'd0, u, v}, 64'd3);

    // R3: pointer load, alone and with a fill in the same cycle
    @(negedge clk); rp_we = 1; rp_wdata = 4'd3;
    @(negedge clk); rp_we = 0; m_ptr = 3;
    chk(repl_ptr == 3, "R3 load", 64'(repl_ptr), 3);
    fill(vpn_of(3), m_ctx[3], 64'h3333_AAAA_3333_AAAA, 1, 4'd12);
    chk(repl_ptr == 12, "R3 load beats advance", 64'(repl_ptr), 12);
    lookup(vpn_of(3), m_ctx[3], "R3 fill at old ptr");

    // R4: direct write, pointer untouched
    direct_wr(7, 51'h1_2345, 13'd6, 64'h7777_0000_1234_5678);
    chk(repl_ptr == 12, "R4 ptr unchanged", 64'(repl_ptr), 12);
    lookup(51'h1_2345, 13'd6, "R4 lookup");
    lookup(vpn_of(7), 13'd4, "R4 old tag gone");

    // R8: duplicate page via fill at pointer 12
    fill(vpn_of(2), m_ctx[2], 64'hBAD0_BAD0_BAD0_BAD0, 0, '0);
    lookup(vpn_of(2), m_ctx[2], "R8 multi");
    chk(lk_multi == 1, "R8 flag", 64'(lk_multi), 1);

    // R9: demap page clears both copies, nothing else
    ctx_pri = m_ctx[2];
    demap(dm_word(vpn_of(2), 0, 2'd0));
    sweep("R9 sweep");

    // R9: right page, wrong context has no effect
    ctx_pri = 13'd1;
    demap(dm_word(vpn_of(5), 0, 2'd0));
    lookup(vpn_of(5), m_ctx[5], "R9 ctx mismatch kept");

    // R10/R11: demap context via secondary select
    ctx_sec = 13'd4;
    demap(dm_word(51'h0, 1, 2'd1));
    sweep("R10 sweep");

    // R11: nucleus select
    direct_wr(0, 51'h5_0505, 13'd0, 64'h0000_0505_0000_0505);
    direct_wr(9, 51'h5_0606, 13'd0, 64'h0000_0606_0000_0606);
    lookup(51'h5_0505, 13'd0, "R11 nucleus present");
    demap(dm_word(51'h0, 1, 2'd2));
    sweep("R11 nucleus sweep");

    // R11: select 3 does nothing
    ctx_pri = 13'd1; ctx_sec = 13'd1;
    demap(dm_word(51'h0, 1, 2'd3));
    sweep("R11 none sweep");

    // R12: lookup and demap in the same cycle
    @(negedge clk);
    ctx_pri = m_ctx[5];
    lk_req = 1; lk_vpn = vpn_of(5); lk_ctx = m_ctx[5];
    mnt_we = 1; mnt_sel = 2'd3; mnt_va = dm_word(vpn_of(5), 0, 2'd0);
    @(negedge clk);
    lk_req = 0; mnt_we = 0;
    lk_expect(vpn_of(5), m_ctx[5], "R12 same cycle sees old");
    model_demap(dm_word(vpn_of(5), 0, 2'd0));
    lookup(vpn_of(5), m_ctx[5], "R12 next sees new");
    chk(lk_hit == 0, "R12 miss", 64'(lk_hit), 0);

    // R1: reset clears everything again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_ptr = 0;
    chk(repl_ptr == 0, "R1 ptr after reset", 64'(repl_ptr), 0);
    sweep("R1 sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule